// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write-Once Control

This block is a watchdog timer for a small controller. Software picks one of seven timeout rates in an 8-bit control register. It then has to keep the watchdog alive by writing a two-byte key to a separate arm register. The first key byte, 0x55, arms the service. The second, 0xAA, completes it and restarts the count. If the count runs out, if an unknown byte reaches the arm register, or if 0xAA arrives without a preceding 0x55, the block raises a one-cycle reset request for the system reset controller.

In window mode a service write must fall in the final quarter of the period. Any earlier arm write counts as a violation. Outside special mode the configuration is write-once after reset. A write-mask bit in the written byte lets the debug-stop bit be set without touching, or locking, the other fields. Two stop conditions are available. While the chip waits, the counter can be held at zero. While a debugger is active, the counter can be frozen.

The service logic is a four-state machine:
- `ST_OFF`: rate code 000, so the watchdog is disabled.
- `ST_CLOSED`: window mode, in the first three quarters of the period.
- `ST_OPEN`: service writes are accepted but no 0x55 has been seen yet.
- `ST_KEYED`: 0x55 has been seen.

Its transitions are:
- **open-window**: `ST_CLOSED` to `ST_OPEN` when three quarters of the period have elapsed.
- **arm**: `ST_OPEN` to `ST_KEYED` on 0x55.
- **re-arm**: `ST_KEYED` stays in `ST_KEYED` on a further 0x55.
- **service**: `ST_KEYED` back to base on 0xAA.
- **violation**: any arm write in `ST_CLOSED`, or a wrong byte in `ST_OPEN` or `ST_KEYED`, returns to base.
- **timeout**: returns to base.
- **restart**: a control restart event, or the wait hold, returns to base.
- **enable**: `ST_OFF` to base when a non-zero rate is written.

Here base means `ST_CLOSED` in window mode and `ST_OPEN` otherwise.

Top module: `wdg_window`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00 with the default parameters and `rst_req` is low.
- R2: Control byte layout (bus_sel=0):
  - bit 7: window enable
  - bit 6: debug-stop
  - bit 5: write mask, which always reads 0
  - bit 4: stop-in-wait
  - bit 3: reset-stop, which is stored and read back only
  - bits 2:0: rate code
  
  The arm register is selected with bus_sel=1.
- R3: Outside special mode, the first unmasked control write locks the window, stop-in-wait, reset-stop and rate fields, and later writes leave them unchanged. In special mode these fields can be written at any time.
- R4: Writing rate 000 leaves the rate unchanged, and writing window enable as 0 leaves it unchanged. Outside special mode, such a write still uses up the single permitted write.
- R5: A control write with bit 5 set leaves the window, stop-in-wait, reset-stop and rate fields unchanged and does not use up the permitted write.
- R6: Outside special mode, the debug-stop bit can only go from 0 to 1. In special mode it takes the written value.
- R7: Rate codes 1 to 7 give a period of 2^(E-SHRINK) clocks, with E equal to 14, 16, 18, 20, 22, 23 and 24 respectively. With no service, `rst_req` pulses for one cycle exactly one period after a restart.
- R8: Writing 0x55 (repeatable) followed by 0xAA to the arm register restarts the count.
- R9: With the watchdog enabled, an arm write of any byte other than 0x55 or 0xAA raises `rst_req`. So does 0xAA written without a preceding 0x55.
- R10: In window mode, an arm write in the first three quarters of the period raises `rst_req`. After a completed service, the window is closed again.
- R11: The count restarts on an applied non-zero rate write, and on debug-stop going from 0 to 1.
- R12: With stop-in-wait set, while `wait_mode` is high the counter is held at zero and no timeout occurs.
- R13: With debug-stop set, while `debug_active` is high the count is frozen. It resumes from the same value afterwards.
- R14: With rate 000, arm writes are ignored and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 allows control writes at any time |
| wait_mode | input | 1 | Chip is in wait state |
| debug_active | input | 1 | Debugger has halted the core |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_sel | input | 1 | 0 selects control, 1 selects arm register |
| bus_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Control register readback |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A write presented in one cycle is captured at the next rising edge. Its effect on `ctl_rdata` and on `rst_req` appears right after that edge, so the bench samples on the falling edge that ends each write.

After a restart edge the counter is zero. An arm write issued after k idle cycles therefore sees count k. The window opens for k at least 3/4 of the period. A timeout appears after exactly one period of idle cycles.

The bench counts idle cycles from each restart and checks that `rst_req` is low one cycle before its due edge and high at that edge. A request that comes too early, too late or not at all is therefore caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CLOSED,
        ST_OPEN,
        ST_KEYED
    } wdg_state_e;

    typedef struct packed {
        logic       win;
        logic       dbg;
        logic       swait;
        logic       rstop;
        logic [2:0] rate;
    } wdg_ctl_t;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;
    localparam int         MAX_EXP  = 24;

    localparam int BIT_WIN   = 7;
    localparam int BIT_DBG   = 6;
    localparam int BIT_MASK  = 5;
    localparam int BIT_SWAIT = 4;
    localparam int BIT_RSTOP = 3;

    // log2 of the period for each rate code
    function automatic int rate_exp(input logic [2:0] code);
        int e;
        case (code)
            3'd1:    e = 14;
            3'd2:    e = 16;
            3'd3:    e = 18;
            3'd4:    e = 20;
            3'd5:    e = 22;
            3'd6:    e = 23;
            3'd7:    e = 24;
            default: e = 14;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
    import wdg_pkg::*;
#(
    parameter logic [2:0] RESET_RATE = 3'd0,
    parameter logic       RESET_WIN  = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     special_mode,
    input  logic     ctl_wr,
    input  logic [7:0] wdata,
    output wdg_ctl_t ctl_q,
    output logic     win_next,
    output logic     rate_on_next,
    output logic     restart_o
);

    wdg_ctl_t ctl_d;
    logic     locked_q, locked_d;
    logic     rate_hit, dbg_rise;

    always_comb begin
        ctl_d    = ctl_q;
        locked_d = locked_q;
        rate_hit = 1'b0;
        dbg_rise = 1'b0;
        if (ctl_wr) begin
            // debug-stop ignores the mask; set-only in normal mode
            if (special_mode) begin
                ctl_d.dbg = wdata[BIT_DBG];
            end else begin
                ctl_d.dbg = ctl_q.dbg | wdata[BIT_DBG];
            end
            dbg_rise = !ctl_q.dbg && wdata[BIT_DBG];
            if (!wdata[BIT_MASK]) begin
                if (special_mode || !locked_q) begin
                    ctl_d.win   = ctl_q.win | wdata[BIT_WIN];
                    ctl_d.swait = wdata[BIT_SWAIT];
                    ctl_d.rstop = wdata[BIT_RSTOP];
                    if (wdata[2:0] != 3'd0) begin
                        ctl_d.rate = wdata[2:0];
                        rate_hit   = 1'b1;
                    end
                end
                if (!special_mode) begin
                    locked_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '{win: RESET_WIN, dbg: 1'b0, swait: 1'b0,
                          rstop: 1'b0, rate: RESET_RATE};
            locked_q <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            locked_q <= locked_d;
        end
    end

    assign win_next     = ctl_d.win;
    assign rate_on_next = (ctl_d.rate != 3'd0);
    assign restart_o    = rate_hit | dbg_rise;

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int SHRINK = 0,
    parameter int CNT_W  = MAX_EXP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate,
    input  logic       freeze,
    input  logic       hold,
    input  logic       clr,
    output logic       q3_hit,
    output logic       end_hit
);

    localparam logic [CNT_W:0]   ONE_W = (CNT_W+1)'(1);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   per, q3;
    logic [5:0]       sh;
    logic             run, counting;

    always_comb begin
        run      = (rate != 3'd0);
        sh       = 6'(rate_exp(rate) - SHRINK);
        per      = ONE_W << sh;
        q3       = per - (per >> 2);
        counting = run && !freeze && !hold;
        q3_hit   = counting && ({1'b0, cnt_q} == (q3 - ONE_W));
        end_hit  = counting && ({1'b0, cnt_q} == (per - ONE_W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (counting) begin
            cnt_q <= cnt_q + ONE_C;
        end
    end

endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
#(
    parameter logic RESET_ON  = 1'b0,
    parameter logic RESET_WIN = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_cur,
    input  logic       win_next,
    input  logic       rate_on_next,
    input  logic       ext_restart,
    input  logic       hold,
    input  logic       q3_hit,
    input  logic       end_hit,
    input  logic       arm_wr,
    input  logic [7:0] arm_data,
    output logic       fsm_restart,
    output logic       rst_req
);

    localparam wdg_state_e ST_INIT = !RESET_ON ? ST_OFF :
                                     (RESET_WIN ? ST_CLOSED : ST_OPEN);

    wdg_state_e state_q, state_d;
    logic       viol, serv, tmo;

    function automatic wdg_state_e base_of(input logic win);
        return win ? ST_CLOSED : ST_OPEN;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        viol    = 1'b0;
        serv    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_CLOSED: begin
                if (arm_wr) begin
                    viol = 1'b1;
                end else if (q3_hit) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (arm_wr) begin
                    if (arm_data == KEY_ARM) begin
                        state_d = ST_KEYED;
                    end else begin
                        viol = 1'b1;
                    end
                end
            end
            ST_KEYED: begin
                if (arm_wr) begin
                    if (arm_data == KEY_ARM) begin
                        state_d = ST_KEYED;
                    end else if (arm_data == KEY_FIRE) begin
                        serv = 1'b1;
                    end else begin
                        viol = 1'b1;
                    end
                end
            end
        endcase
        tmo         = end_hit && (state_q != ST_OFF);
        fsm_restart = viol || tmo || serv;
        if (fsm_restart) begin
            state_d = base_of(win_cur);
        end
        if (ext_restart || hold) begin
            state_d = base_of(win_next);
        end
        if (!rate_on_next) begin
            state_d = ST_OFF;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= viol || tmo;
        end
    end

endmodule

// File: rtl/wdg_window.sv
module wdg_window
    import wdg_pkg::*;
#(
    parameter int         SHRINK     = 0,
    parameter logic [2:0] RESET_RATE = 3'd0,
    parameter logic       RESET_WIN  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       wait_mode,
    input  logic       debug_active,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] ctl_rdata,
    output logic       rst_req
);

    localparam logic RESET_ON = (RESET_RATE != 3'd0);

    wdg_ctl_t ctl_q;
    logic     win_next, rate_on_next, ctl_restart, fsm_restart;
    logic     hold, freeze, clr, q3_hit, end_hit;
    logic     ctl_wr, arm_wr;

    assign ctl_wr = bus_wr && !bus_sel;
    assign arm_wr = bus_wr && bus_sel;
    assign hold   = wait_mode && ctl_q.swait;
    assign freeze = debug_active && ctl_q.dbg;
    assign clr    = ctl_restart || fsm_restart || hold;

    wdg_ctl_reg #(
        .RESET_RATE (RESET_RATE),
        .RESET_WIN  (RESET_WIN)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .ctl_wr       (ctl_wr),
        .wdata        (bus_wdata),
        .ctl_q        (ctl_q),
        .win_next     (win_next),
        .rate_on_next (rate_on_next),
        .restart_o    (ctl_restart)
    );

    wdg_prescaler #(
        .SHRINK (SHRINK),
        .CNT_W  (MAX_EXP)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (ctl_q.rate),
        .freeze  (freeze),
        .hold    (hold),
        .clr     (clr),
        .q3_hit  (q3_hit),
        .end_hit (end_hit)
    );

    wdg_key_fsm #(
        .RESET_ON  (RESET_ON),
        .RESET_WIN (RESET_WIN)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_cur      (ctl_q.win),
        .win_next     (win_next),
        .rate_on_next (rate_on_next),
        .ext_restart  (ctl_restart),
        .hold         (hold),
        .q3_hit       (q3_hit),
        .end_hit      (end_hit),
        .arm_wr       (arm_wr),
        .arm_data     (bus_wdata),
        .fsm_restart  (fsm_restart),
        .rst_req      (rst_req)
    );

    assign ctl_rdata = {ctl_q.win, ctl_q.dbg, 1'b0, ctl_q.swait,
                        ctl_q.rstop, ctl_q.rate};

endmodule

// File: rtl/wdg_window_chk.sv
module wdg_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       special_mode,
    input logic       wait_mode,
    input logic       bus_wr,
    input logic       bus_sel,
    input logic [7:0] bus_wdata,
    input logic [7:0] ctl_rdata,
    input logic       rst_req
);

    logic lock_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_c <= 1'b0;
        end else if (bus_wr && !bus_sel && !bus_wdata[5] && !special_mode) begin
            lock_c <= 1'b1;
        end
    end

    // R2
    mask_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5] == 1'b0);

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && bus_wdata[5])
        |=> $stable({ctl_rdata[7], ctl_rdata[4:0]}));

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_c && !special_mode)
        |=> $stable({ctl_rdata[7], ctl_rdata[4:0]}));

    // R6
    dbg_setonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && ctl_rdata[6]) |=> ctl_rdata[6]);

    // R14
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[2:0] == 3'd0) |=> !rst_req);

    // R9
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && ctl_rdata[2:0] != 3'd0 &&
         bus_wdata != 8'h55 && bus_wdata != 8'hAA) |=> rst_req);

    // R12
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && ctl_rdata[4] && !(bus_wr && bus_sel)) |=> !rst_req);

endmodule

bind wdg_window wdg_window_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wait_mode    (wait_mode),
    .bus_wr       (bus_wr),
    .bus_sel      (bus_sel),
    .bus_wdata    (bus_wdata),
    .ctl_rdata    (ctl_rdata),
    .rst_req      (rst_req)
);

// File: tb/wdg_window_tb.sv
module wdg_window_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  SHRINK     = 10;
    localparam int  WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       wait_mode = 1'b0;
    logic       debug_active = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdg_window #(.SHRINK(SHRINK)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wait_mode    (wait_mode),
        .debug_active (debug_active),
        .bus_wr       (bus_wr),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .ctl_rdata    (ctl_rdata),
        .rst_req      (rst_req)
    );

    // {special, write data, expected readback}, walked after one reset
    localparam logic [16:0] TBL [8] = '{
        {1'b0, 8'h21, 8'h00},   // R5 masked write: no change, no lock
        {1'b0, 8'h00, 8'h00},   // R4 zero write: no change, but locks
        {1'b0, 8'h92, 8'h00},   // R3 locked: ignored
        {1'b0, 8'h40, 8'h40},   // R6 debug-stop set
        {1'b0, 8'h00, 8'h40},   // R6 clear ignored in normal mode
        {1'b1, 8'h9A, 8'h9A},   // R3 special mode writes anytime
        {1'b1, 8'h00, 8'h82},   // R4 rate/window keep, others follow
        {1'b1, 8'h28, 8'h82}    // R2 mask bit reads 0, R5 masked
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        bus_sel   = sel;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n        = 1'b0;
        special_mode = 1'b0;
        wait_mode    = 1'b0;
        debug_active = 1'b0;
        bus_wr       = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // expect silence for n-1 cycles, then a pulse, then silence
    task automatic expect_timeout(input string req, input int n);
        idle(n - 1);
        check(req, {7'd0, rst_req}, 8'h00);
        idle(1);
        check(req, {7'd0, rst_req}, 8'h01);
        idle(1);
        check(req, {7'd0, rst_req}, 8'h00);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 readback", ctl_rdata, 8'h00);
        check("R1 rst_req", {7'd0, rst_req}, 8'h00);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            special_mode = TBL[i][16];
            bus_write(1'b0, TBL[i][15:8]);
            check($sformatf("R2-layout table entry %0d", i), ctl_rdata, TBL[i][7:0]);
            check($sformatf("table entry %0d no request", i), {7'd0, rst_req}, 8'h00);
        end
        special_mode = 1'b0;

        // R7 normal-mode timeout, rate 1 -> 16 cycles
        do_reset();
        bus_write(1'b0, 8'h01);
        check("R7 rate1 readback", ctl_rdata, 8'h01);
        expect_timeout("R7 rate1 period", 16);

        // R8 service with repeated 0x55
        do_reset();
        bus_write(1'b0, 8'h01);
        idle(5);
        bus_write(1'b1, 8'h55);
        check("R8 first 55", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'h55);
        check("R8 repeat 55", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'hAA);
        check("R8 AA accepted", {7'd0, rst_req}, 8'h00);
        expect_timeout("R8 restart after service", 16);

        // R9 bad keys
        bus_write(1'b1, 8'h12);
        check("R9 unknown byte", {7'd0, rst_req}, 8'h01);
        bus_write(1'b1, 8'hAA);
        check("R9 AA without 55", {7'd0, rst_req}, 8'h01);

        // R10 window mode, period 16, window from count 12
        do_reset();
        bus_write(1'b0, 8'h81);
        idle(11);
        bus_write(1'b1, 8'h55);
        check("R10 early write", {7'd0, rst_req}, 8'h01);
        idle(12);
        bus_write(1'b1, 8'h55);
        check("R10 write at window edge", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'hAA);
        check("R10 service in window", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'h55);
        check("R10 window closed after service", {7'd0, rst_req}, 8'h01);
        idle(12);
        bus_write(1'b1, 8'h55);
        bus_write(1'b1, 8'h55);
        check("R8 repeated 55 in window", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'hAA);
        check("R8 window service", {7'd0, rst_req}, 8'h00);
        expect_timeout("R10 period after service", 16);

        // R12 stop-in-wait
        do_reset();
        bus_write(1'b0, 8'h11);
        idle(10);
        wait_mode = 1'b1;
        idle(30);
        check("R12 no timeout in wait", {7'd0, rst_req}, 8'h00);
        wait_mode = 1'b0;
        expect_timeout("R12 count restarted from zero", 16);

        // R13 debug freeze
        do_reset();
        bus_write(1'b0, 8'h41);
        idle(10);
        debug_active = 1'b1;
        idle(40);
        check("R13 no timeout while frozen", {7'd0, rst_req}, 8'h00);
        debug_active = 1'b0;
        expect_timeout("R13 count resumes", 6);

        // R11 debug-stop rise restarts
        do_reset();
        bus_write(1'b0, 8'h01);
        idle(10);
        bus_write(1'b0, 8'h40);
        check("R11 readback", ctl_rdata, 8'h41);
        expect_timeout("R11 restart on debug-stop set", 16);

        // R11 rate write restarts (special mode)
        do_reset();
        special_mode = 1'b1;
        bus_write(1'b0, 8'h01);
        idle(10);
        bus_write(1'b0, 8'h02);
        expect_timeout("R11 restart on rate write", 64);
        special_mode = 1'b0;

        // R14 disabled watchdog
        do_reset();
        bus_write(1'b1, 8'h12);
        check("R14 bad byte ignored", {7'd0, rst_req}, 8'h00);
        bus_write(1'b1, 8'hAA);
        check("R14 AA ignored", {7'd0, rst_req}, 8'h00);
        idle(200);
        check("R14 no timeout", {7'd0, rst_req}, 8'h00);

        // R7 longer rates
        do_reset();
        bus_write(1'b0, 8'h03);
        expect_timeout("R7 rate3 period", 256);
        do_reset();
        bus_write(1'b0, 8'h06);
        expect_timeout("R7 rate6 period", 8192);
        do_reset();
        bus_write(1'b0, 8'h07);
        expect_timeout("R7 rate7 period", 16384);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule